// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits on the controller side of a two-wire serial bus. It returns the bus to a known idle state after a transfer was cut short by a reset, a brown-out or a software fault. When it is triggered, it drives the open-drain SCL and SDA enables through a fixed pattern. The pattern is a Start condition, nine dummy clock pulses with SDA released, a second Start and a final Stop. Releasing SDA during the dummy clocks lets a target that was caught mid-byte shift out its remaining bits and let go of the data line.

The Start is a falling SDA edge while SCL is high, and the Stop is a rising SDA edge while SCL is high. An initial Start can only be produced when SDA is high. If SDA is already held low at the trigger, the block skips the first Start and goes straight to the dummy clocks. Each SCL phase lasts `PHASE_CYC` system clocks, and every SDA change sits at the midpoint of a phase.

After the Stop, the block leaves the bus released for half a phase and then samples SDA. It then pulses `done_o`. If SDA is still low at that point, it also pulses `stuck_o`, so that the system can escalate to a power cycle of the target.

Top module: `bus_recover_seq`

## Requirements
- R1: While reset is asserted and after it is released, `scl_oe_o`, `sda_oe_o`, `done_o` and `stuck_o` are all 0 until a trigger arrives. An enable of 1 means the line is pulled low.
- R2: When a trigger is accepted with SDA high, the first bus event is a Start: SDA falls while SCL is still released.
- R3: After the leading Start, or after the trigger when that Start is skipped, SCL makes exactly nine high pulses. SDA has no edge and `sda_oe_o` is 0 during each of their high phases.
- R4: After the nine pulses, SCL rises once more and SDA falls (a second Start). SCL then goes low, rises again and SDA rises (a Stop). Both lines are then left released. The full bus event order is Start, nine clock rises, a rise, Start, a rise, Stop.
- R5: Within a sequence, every SCL low phase and every SCL high phase after the first SCL fall lasts exactly `PHASE_CYC` clocks. Each change of `sda_oe_o` after the first SCL fall happens `PHASE_CYC/2` clocks after the latest SCL edge.
- R6: When SDA is low at the trigger, no leading Start is made. SCL is pulled low first, and the nine pulses, the second Start and the Stop follow as in R3 and R4.
- R7: `done_o` is high for exactly one cycle. It is visible `49*PHASE_CYC/2` rising edges after the edge that accepted the trigger, or `45*PHASE_CYC/2` edges when the leading Start was skipped.
- R8: `stuck_o` pulses in the same cycle as `done_o` if SDA is low when sampled half a phase after the Stop. Otherwise it stays 0. It never pulses on its own.
- R9: A trigger is ignored while a sequence runs, up to and including the cycle before `done_o`. A trigger present in the cycle where `done_o` is high starts a new sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Request a recovery sequence, sampled only when idle |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| done_o | output | 1 | One-cycle pulse when the sequence has finished |
| stuck_o | output | 1 | One-cycle pulse with `done_o` when SDA is still low |

## Verification
Completion and a new trigger can land in the same cycle. So can completion and the stuck flag. The bench sweeps an extra trigger pulse across every cycle of a running sequence. A trigger up to the cycle before `done_o` must leave exactly one completion and an unchanged event order. A trigger sampled while `done_o` is high must produce a second full sequence. The stuck flag is provoked with a modelled target that holds SDA low through the whole sequence, and with targets that let go after each possible number of dummy clocks. In those runs the bench checks that `stuck_o` coincides with `done_o` only when SDA stays low.

// File: rtl/brs_pkg.sv
package brs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,     // leading Start slot
    ST_PULSE,    // dummy clock slots
    ST_RESTART,  // second Start slot
    ST_STOP,
    ST_CHECK     // quiet quarter, then SDA sample
  } brs_state_e;
endpackage

// File: rtl/brs_qtimer.sv
module brs_qtimer #(
  parameter int QTR = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (QTR > 1) ? $clog2(QTR) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!run_i)                  cnt_q <= '0;
    else if (cnt_q == CW'(QTR - 1))   cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == CW'(QTR - 1));
endmodule

// File: rtl/brs_fsm.sv
module brs_fsm
  import brs_pkg::*;
#(
  parameter int NUM_CLKS = 9,
  parameter int BW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trig_i,
  input  logic          sda_i,
  input  logic          tick_i,
  output brs_state_e    st_o,
  output logic [1:0]    qtr_o,
  output logic [BW-1:0] bit_o,
  output logic          lead_o,
  output logic          done_o,
  output logic          stuck_o
);
  brs_state_e    st_q, st_d;
  logic [1:0]    q_q, q_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          lead_q, lead_d;
  logic          fin;

  assign fin = (st_q == ST_CHECK) && tick_i;

  always_comb begin
    st_d   = st_q;
    q_d    = q_q;
    bit_d  = bit_q;
    lead_d = lead_q;
    if (st_q == ST_IDLE) begin
      if (trig_i) begin
        lead_d = sda_i;
        st_d   = sda_i ? ST_LEAD : ST_PULSE;
        q_d    = '0;
        bit_d  = '0;
      end
    end else if (tick_i) begin
      if (st_q == ST_CHECK) begin
        st_d = ST_IDLE;
      end else begin
        q_d = q_q + 2'd1;
        if (q_q == 2'd3) begin
          unique case (st_q)
            ST_LEAD:    st_d = ST_PULSE;
            ST_PULSE: begin
              if (bit_q == BW'(NUM_CLKS - 1)) st_d = ST_RESTART;
              else                            bit_d = bit_q + 1'b1;
            end
            ST_RESTART: st_d = ST_STOP;
            ST_STOP:    st_d = ST_CHECK;
            default:    st_d = ST_IDLE;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      q_q     <= '0;
      bit_q   <= '0;
      lead_q  <= 1'b0;
      done_o  <= 1'b0;
      stuck_o <= 1'b0;
    end else begin
      st_q    <= st_d;
      q_q     <= q_d;
      bit_q   <= bit_d;
      lead_q  <= lead_d;
      done_o  <= fin;
      stuck_o <= fin && !sda_i;
    end
  end

  assign st_o   = st_q;
  assign qtr_o  = q_q;
  assign bit_o  = bit_q;
  assign lead_o = lead_q;

  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && !tick_i) |=> $stable(st_q));
  // R7
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  stuck_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stuck_o |-> done_o);
  // R3
  pulse_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PULSE) |-> (bit_q <= BW'(NUM_CLKS - 1)));
endmodule

// File: rtl/brs_drive.sv
module brs_drive
  import brs_pkg::*;
#(
  parameter int NUM_CLKS = 9,
  parameter int BW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  brs_state_e    st_i,
  input  logic [1:0]    qtr_i,
  input  logic [BW-1:0] bit_i,
  input  logic          lead_i,
  output logic          scl_oe_o,
  output logic          sda_oe_o
);
  logic scl_d, sda_d;

  // quarters 0..1 of a slot are SCL low, 2..3 SCL high
  always_comb begin
    scl_d = 1'b0;
    sda_d = 1'b0;
    unique case (st_i)
      ST_LEAD:    sda_d = qtr_i[1];
      ST_PULSE: begin
        scl_d = !qtr_i[1];
        sda_d = (qtr_i == 2'd0) && (bit_i == '0) && lead_i;
      end
      ST_RESTART: begin
        scl_d = !qtr_i[1];
        sda_d = (qtr_i == 2'd3);
      end
      ST_STOP: begin
        scl_d = !qtr_i[1];
        sda_d = (qtr_i != 2'd3);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_oe_o <= 1'b0;
      sda_oe_o <= 1'b0;
    end else begin
      scl_oe_o <= scl_d;
      sda_oe_o <= sda_d;
    end
  end

  // R5
  sda_edge_scl_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_oe_o && !$past(scl_oe_o) && (sda_oe_o != $past(sda_oe_o)))
      |-> ($past(st_i) == ST_LEAD || $past(st_i) == ST_RESTART || $past(st_i) == ST_STOP));
endmodule

// File: rtl/bus_recover_seq.sv
module bus_recover_seq
  import brs_pkg::*;
#(
  parameter int PHASE_CYC = 10,  // system clocks per SCL phase, even and >= 2
  parameter int NUM_CLKS  = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic sda_i,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic done_o,
  output logic stuck_o
);
  localparam int QTR = PHASE_CYC / 2;
  localparam int BW  = (NUM_CLKS > 1) ? $clog2(NUM_CLKS) : 1;

  brs_state_e    st;
  logic [1:0]    qtr;
  logic [BW-1:0] bit_idx;
  logic          lead;
  logic          tick;

  brs_qtimer #(.QTR(QTR)) u_qtimer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (st != ST_IDLE),
    .tick_o (tick)
  );

  brs_fsm #(.NUM_CLKS(NUM_CLKS), .BW(BW)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (trig_i),
    .sda_i   (sda_i),
    .tick_i  (tick),
    .st_o    (st),
    .qtr_o   (qtr),
    .bit_o   (bit_idx),
    .lead_o  (lead),
    .done_o  (done_o),
    .stuck_o (stuck_o)
  );

  brs_drive #(.NUM_CLKS(NUM_CLKS), .BW(BW)) u_drive (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .st_i     (st),
    .qtr_i    (qtr),
    .bit_i    (bit_idx),
    .lead_i   (lead),
    .scl_oe_o (scl_oe_o),
    .sda_oe_o (sda_oe_o)
  );

  // R1
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE && $past(st) == ST_IDLE) |=> (!scl_oe_o && !sda_oe_o));
endmodule

// File: tb/bus_recover_seq_bench.sv
module bus_recover_seq_bench;
  localparam int PC  = 4;
  localparam int QTR = PC / 2;
  localparam int DN  = 1 + 49 * QTR;  // done iteration, leading Start
  localparam int DS  = 1 + 45 * QTR;  // done iteration, Start skipped
  localparam int W   = DN + 3 * PC;

  logic clk = 1'b0, rst_n = 1'b0, trig = 1'b0, hold = 1'b0;
  logic scl_oe, sda_oe, done, stuck;
  wire  scl_bus = ~scl_oe;
  wire  sda_bus = ~sda_oe & ~hold;

  bus_recover_seq #(.PHASE_CYC(PC), .NUM_CLKS(9)) u_bus_recover_seq (
    .clk_i (clk), .rst_ni (rst_n), .trig_i (trig), .sda_i (sda_bus),
    .scl_oe_o (scl_oe), .sda_oe_o (sda_oe), .done_o (done), .stuck_o (stuck)
  );

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  int ev [64];
  int n_ev, ex [32], n_ex;
  int n_rise, n_fall, run_len, phase_bad, mid_bad;
  int done_cnt, stuck_cnt, stuck_alone;
  logic prev_scl = 1'b1, prev_sda = 1'b1, prev_oe = 1'b0;

  task automatic push(input int e);
    if (n_ev < 64) ev[n_ev] = e;
    n_ev++;
  endtask

  // event codes: 1 Start, 2 SCL rise, 3 Stop
  always @(negedge clk) if (rst_n) begin
    if (scl_bus && prev_scl && !sda_bus && prev_sda) push(1);
    if (scl_bus && prev_scl && sda_bus && !prev_sda) push(3);
    if (scl_bus && !prev_scl) begin
      push(2);
      n_rise++;
      if (run_len != PC) phase_bad++;
    end
    if (!scl_bus && prev_scl) begin
      if (n_fall > 0 && run_len != PC) phase_bad++;
      n_fall++;
    end
    run_len = (scl_bus != prev_scl) ? 1 : run_len + 1;
    if (sda_oe != prev_oe && n_fall > 0 && run_len != QTR + 1) mid_bad++;
    if (done) done_cnt++;
    if (stuck) begin
      stuck_cnt++;
      if (!done) stuck_alone++;
    end
    prev_scl = scl_bus;
    prev_sda = sda_bus;
    prev_oe  = sda_oe;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    n_ev = 0; n_rise = 0; n_fall = 0; run_len = 1;
    phase_bad = 0; mid_bad = 0;
    done_cnt = 0; stuck_cnt = 0; stuck_alone = 0;
  endtask

  task automatic addx(input int e, input int n);
    for (int i = 0; i < n; i++) begin
      ex[n_ex] = e;
      n_ex++;
    end
  endtask

  // 0 normal, 1 skip + release by 9th rise, 2 release after 10th, 3 never
  task automatic build_exp(input int code);
    n_ex = 0;
    if (code == 0) addx(1, 1);
    addx(2, (code >= 2) ? 11 : 10);
    if (code <= 1) begin
      addx(1, 1); addx(2, 1); addx(3, 1);
    end else if (code == 2) addx(3, 1);
  endtask

  task automatic cmp_events(input string req, input int reps);
    int first_bad;
    first_bad = -1;
    for (int k = 0; k < n_ev && k < 64; k++)
      if (first_bad < 0 && (k >= reps * n_ex || ev[k] != ex[k % n_ex])) first_bad = k;
    chk(n_ev == reps * n_ex && first_bad < 0, req, n_ev * 100 + first_bad, reps * n_ex * 100 - 1);
  endtask

  task automatic run_seq(input bit hmode, input int rel_k, input int inj, input int win,
                         output int lat);
    hold = hmode;
    repeat (2 * PC) @(posedge clk);
    #1;
    clear_log();
    trig = 1'b1;
    lat = 0;
    for (int i = 1; i <= win; i++) begin
      @(posedge clk);
      #1;
      if (i == 1) trig = 1'b0;
      if (inj != 0 && i == inj) trig = 1'b1;
      if (inj != 0 && i == inj + 1) trig = 1'b0;
      if (hold && n_rise >= rel_k && !scl_bus) hold = 1'b0;
      if (done && lat == 0) lat = i;
    end
    trig = 1'b0;
  endtask

  initial begin
    int lat;
    clear_log();
    repeat (4) @(posedge clk);
    #1;
    chk(!scl_oe && !sda_oe && !done && !stuck, "R1 in reset", {scl_oe, sda_oe, done, stuck}, 0);
    rst_n = 1'b1;
    repeat (6) @(posedge clk);
    #1;
    chk(!scl_oe && !sda_oe && !done && !stuck, "R1 after reset", {scl_oe, sda_oe, done, stuck}, 0);

    // normal sequence with leading Start
    build_exp(0);
    run_seq(1'b0, 0, 0, W, lat);
    cmp_events("R2 R3 R4 event order", 1);
    chk(phase_bad == 0 && mid_bad == 0, "R5 phase timing", phase_bad * 1000 + mid_bad, 0);
    chk(lat == DN, "R7 done latency", lat, DN);
    chk(done_cnt == 1, "R7 done width", done_cnt, 1);
    chk(stuck_cnt == 0, "R8 no stuck", stuck_cnt, 0);

    // SDA held at trigger, released after k rises (99 = never)
    for (int k = 0; k <= 11; k++) begin
      int rk, code;
      rk   = (k == 11) ? 99 : k;
      code = (k <= 9) ? 1 : (k == 10) ? 2 : 3;
      build_exp(code);
      run_seq(1'b1, rk, 0, W, lat);
      cmp_events("R6 R3 skip events", 1);
      chk(phase_bad == 0 && mid_bad == 0, "R5 skip timing", phase_bad * 1000 + mid_bad, 0);
      chk(lat == DS, "R7 skip latency", lat, DS);
      chk(done_cnt == 1, "R7 skip done width", done_cnt, 1);
      chk(stuck_cnt == ((k == 11) ? 1 : 0), "R8 stuck flag", stuck_cnt, (k == 11) ? 1 : 0);
      chk(stuck_alone == 0, "R8 stuck alone", stuck_alone, 0);
    end

    // extra trigger at every cycle of a running sequence
    build_exp(0);
    for (int j = 2; j < DN; j++) begin
      run_seq(1'b0, 0, j, W, lat);
      chk(done_cnt == 1, "R9 busy trigger done count", done_cnt, 1);
      cmp_events("R9 busy trigger events", 1);
    end

    // trigger sampled while done is high
    run_seq(1'b0, 0, DN, 2 * DN + 3 * PC, lat);
    chk(done_cnt == 2, "R9 retrigger at done", done_cnt, 2);
    cmp_events("R9 retrigger events", 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule